// File: doc/BRIEF.md
# Scanline Timed Event Scheduler

This block keeps time inside each horizontal video line and raises a fixed series of per-line events at computed positions. Every `step` stands for two master clocks. The horizontal position and a small master-clock phase counter both move forward by two on each step. The block signals four events. The first is a once-per-frame start of the line-based DMA tables, raised on scanline 0 only. The second is a memory refresh, which holds the CPU for 40 master clocks. The third is the start of the per-line DMA transfer. The fourth is the handover at the end of the line. Two of the positions shift with the low three bits of the master clock, so the schedule follows how the line length drifts against an eight-clock grid.

Only one pending event and its trigger position are held, not a flag for every position. The end-of-line event waits for an acknowledge from the video side. Until it arrives, the trigger moves two clocks later and is checked again. The block also gives a dot tick, which steps the pixel pipeline and the IRQ counters.

Top module: `line_event_sched`

## Requirements
- R1: While `rst_n` is low, and until the first step afterwards, every output is low. After reset the position and phase are 0 and the pending event is the refresh at position 538.
- R2: Each step with `step` high adds 2 to the position and 2 to the phase, where the phase is the master count modulo 8. A cycle with `step` low changes nothing: it raises no pulse, raises no dot tick, and keeps `cpu_stall` at its value.
- R3: `dot_tick` is high for the cycle after every step whose resulting position is a multiple of 4. This includes the step that returns the position to 0.
- R4: Each event pulse lasts one cycle after the step that raised it, and at most one event pulse is high at a time. Within a line the order is table init (line 0 only), then refresh, then transfer start, then line end.
- R5: On a line that begins with scanline 0, `evt_hdma_init` fires at position 12 + P. P is the phase after the step that accepted the previous line end.
- R6: `evt_refresh` fires at position 538 − P, with P as in R5. `cpu_stall` goes high with that pulse and stays high for 20 steps, which is 40 master clocks. Cycles without a step do not count toward the 20.
- R7: `evt_hdma_start` fires at position 1104 only when `scanline` was below `vblank_start` at the refresh step. Otherwise the line end follows the refresh directly.
- R8: The line-end check runs at position 1360. If `eol_ack` is low there, the check runs again 2 clocks later, and so on until it is high. `eol_ack` has no effect at any other step, and `evt_line_end` fires only on the accepting step.
- R9: On the accepting step the position becomes 0. The `scanline` value sampled on that step is the new line number: 0 selects table init next, and any other value selects refresh next.
- R10: No other event fires while `cpu_stall` is high. An event whose position has passed by then fires at the first step after the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Advance time by two master clocks |
| scanline | input | 9 | Current line; on the accepting line-end step, the new line |
| vblank_start | input | 9 | First vertical-blank line |
| eol_ack | input | 1 | Video side accepts the line end |
| evt_hdma_init | output | 1 | Per-frame DMA table init pulse |
| evt_refresh | output | 1 | Memory refresh pulse |
| evt_hdma_start | output | 1 | Per-line DMA transfer start pulse |
| evt_line_end | output | 1 | Accepted line-end pulse |
| cpu_stall | output | 1 | CPU held for the refresh window |
| dot_tick | output | 1 | Dot clock tick |

## Verification
The bound checker watches several properties on every cycle. It checks that at most one event pulse is high and that no pulse repeats on consecutive cycles. It checks that idle cycles stay silent and keep the stall flat, and that no event overlaps the stall. It also checks that a line end occurs only with an acknowledge and comes together with a dot tick. Other behaviour depends on phase history across lines, and only the bench's line-by-line scenarios can show it. This covers the exact positions 12 + P and 538 − P after retries shift the phase, the skipped transfer start in blanking, ignored early acknowledges, the 20-step stall length across idle gaps, and the schedule returning after a mid-line reset.

// File: rtl/lse_pkg.sv
`timescale 1ns/1ps
package lse_pkg;
  typedef enum logic [1:0] {
    EV_HDMA_INIT  = 2'd0,
    EV_REFRESH    = 2'd1,
    EV_HDMA_START = 2'd2,
    EV_LINE_END   = 2'd3
  } evt_e;

  typedef struct packed {
    logic hdma_init;
    logic refresh;
    logic hdma_start;
    logic line_end;
  } evt_pulse_t;
endpackage

// File: rtl/lse_hcount.sv
`timescale 1ns/1ps
module lse_hcount #(
  parameter int HPOS_W  = 11,
  parameter int PHASE_W = 3,
  parameter int HSTEP   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               line_restart,
  output logic [HPOS_W-1:0]  hpos_nxt,
  output logic [PHASE_W-1:0] phase_nxt,
  output logic               dot_tick
);
  localparam logic [HPOS_W-1:0]  H_INC = HPOS_W'(HSTEP);
  localparam logic [PHASE_W-1:0] P_INC = PHASE_W'(HSTEP);

  logic [HPOS_W-1:0]  hpos_q, hpos_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               tick_d;

  // next-state
  always_comb begin
    hpos_nxt  = hpos_q + H_INC;
    phase_nxt = phase_q + P_INC;
    hpos_d    = hpos_q;
    phase_d   = phase_q;
    tick_d    = 1'b0;
    if (step) begin
      hpos_d  = line_restart ? '0 : hpos_nxt;
      phase_d = phase_nxt;
      tick_d  = (hpos_d[1:0] == 2'b00);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos_q   <= '0;
      phase_q  <= '0;
      dot_tick <= 1'b0;
    end else begin
      hpos_q   <= hpos_d;
      phase_q  <= phase_d;
      dot_tick <= tick_d;
    end
  end
endmodule

// File: rtl/lse_stall.sv
`timescale 1ns/1ps
module lse_stall #(
  parameter int STALL_STEPS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(STALL_STEPS + 1);
  localparam logic [CW-1:0] LOAD = CW'(STALL_STEPS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (start)              cnt_d = LOAD;
      else if (cnt_q != '0)   cnt_d = cnt_q - ONE;
    end
  end

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lse_event_fsm.sv
`timescale 1ns/1ps
module lse_event_fsm
  import lse_pkg::*;
#(
  parameter int HPOS_W       = 11,
  parameter int PHASE_W      = 3,
  parameter int LINE_W       = 9,
  parameter int HSTEP        = 2,
  parameter int INIT_BASE    = 12,
  parameter int REFRESH_BASE = 538,
  parameter int HSTART_POS   = 1104,
  parameter int LINE_END_POS = 1360
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [HPOS_W-1:0]  hpos_nxt,
  input  logic [PHASE_W-1:0] phase_nxt,
  input  logic [LINE_W-1:0]  scanline,
  input  logic [LINE_W-1:0]  vblank_start,
  input  logic               eol_ack,
  input  logic               stall_busy,
  output logic               line_restart,
  output logic               stall_start,
  output evt_pulse_t         pulses
);
  localparam logic [HPOS_W-1:0] H_INC   = HPOS_W'(HSTEP);
  localparam logic [HPOS_W-1:0] P_INIT  = HPOS_W'(INIT_BASE);
  localparam logic [HPOS_W-1:0] P_REF   = HPOS_W'(REFRESH_BASE);
  localparam logic [HPOS_W-1:0] P_HST   = HPOS_W'(HSTART_POS);
  localparam logic [HPOS_W-1:0] P_LEND  = HPOS_W'(LINE_END_POS);

  evt_e              evt_q, evt_d;
  logic [HPOS_W-1:0] trig_q, trig_d;
  logic [HPOS_W-1:0] refpos_q, refpos_d;
  evt_pulse_t        pulse_d;
  logic [HPOS_W-1:0] phase_ext;
  logic              due;

  assign phase_ext = {{(HPOS_W-PHASE_W){1'b0}}, phase_nxt};
  // reached-or-passed compare lets an event held by the stall fire late
  assign due = step && !stall_busy && (hpos_nxt >= trig_q);

  always_comb begin
    evt_d        = evt_q;
    trig_d       = trig_q;
    refpos_d     = refpos_q;
    pulse_d      = '0;
    line_restart = 1'b0;
    stall_start  = 1'b0;
    if (due) begin
      unique case (evt_q)
        EV_HDMA_INIT: begin
          pulse_d.hdma_init = 1'b1;
          evt_d  = EV_REFRESH;
          trig_d = refpos_q;
        end
        EV_REFRESH: begin
          pulse_d.refresh = 1'b1;
          stall_start     = 1'b1;
          if (scanline < vblank_start) begin
            evt_d  = EV_HDMA_START;
            trig_d = P_HST;
          end else begin
            evt_d  = EV_LINE_END;
            trig_d = P_LEND;
          end
        end
        EV_HDMA_START: begin
          pulse_d.hdma_start = 1'b1;
          evt_d  = EV_LINE_END;
          trig_d = P_LEND;
        end
        EV_LINE_END: begin
          if (eol_ack) begin
            pulse_d.line_end = 1'b1;
            line_restart     = 1'b1;
            refpos_d         = P_REF - phase_ext;
            if (scanline == '0) begin
              evt_d  = EV_HDMA_INIT;
              trig_d = P_INIT + phase_ext;
            end else begin
              evt_d  = EV_REFRESH;
              trig_d = P_REF - phase_ext;
            end
          end else begin
            trig_d = trig_q + H_INC;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q    <= EV_REFRESH;
      trig_q   <= P_REF;
      refpos_q <= P_REF;
      pulses   <= '0;
    end else begin
      evt_q    <= evt_d;
      trig_q   <= trig_d;
      refpos_q <= refpos_d;
      pulses   <= pulse_d;
    end
  end
endmodule

// File: rtl/line_event_sched.sv
`timescale 1ns/1ps
module line_event_sched
  import lse_pkg::*;
#(
  parameter int HPOS_W       = 11,
  parameter int PHASE_W      = 3,
  parameter int LINE_W       = 9,
  parameter int HSTEP        = 2,
  parameter int INIT_BASE    = 12,
  parameter int REFRESH_BASE = 538,
  parameter int HSTART_POS   = 1104,
  parameter int LINE_END_POS = 1360,
  parameter int STALL_MCLK   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [LINE_W-1:0] scanline,
  input  logic [LINE_W-1:0] vblank_start,
  input  logic              eol_ack,
  output logic              evt_hdma_init,
  output logic              evt_refresh,
  output logic              evt_hdma_start,
  output logic              evt_line_end,
  output logic              cpu_stall,
  output logic              dot_tick
);
  localparam int STALL_STEPS = STALL_MCLK / HSTEP;

  logic [HPOS_W-1:0]  hpos_nxt;
  logic [PHASE_W-1:0] phase_nxt;
  logic               line_restart;
  logic               stall_start;
  logic               stall_busy;
  evt_pulse_t         pulses;

  lse_hcount #(.HPOS_W(HPOS_W), .PHASE_W(PHASE_W), .HSTEP(HSTEP)) u_hcount (
    .clk(clk), .rst_n(rst_n), .step(step), .line_restart(line_restart),
    .hpos_nxt(hpos_nxt), .phase_nxt(phase_nxt), .dot_tick(dot_tick)
  );

  lse_stall #(.STALL_STEPS(STALL_STEPS)) u_stall (
    .clk(clk), .rst_n(rst_n), .step(step), .start(stall_start), .busy(stall_busy)
  );

  lse_event_fsm #(
    .HPOS_W(HPOS_W), .PHASE_W(PHASE_W), .LINE_W(LINE_W), .HSTEP(HSTEP),
    .INIT_BASE(INIT_BASE), .REFRESH_BASE(REFRESH_BASE),
    .HSTART_POS(HSTART_POS), .LINE_END_POS(LINE_END_POS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .step(step), .hpos_nxt(hpos_nxt), .phase_nxt(phase_nxt),
    .scanline(scanline), .vblank_start(vblank_start), .eol_ack(eol_ack),
    .stall_busy(stall_busy), .line_restart(line_restart), .stall_start(stall_start),
    .pulses(pulses)
  );

  assign evt_hdma_init  = pulses.hdma_init;
  assign evt_refresh    = pulses.refresh;
  assign evt_hdma_start = pulses.hdma_start;
  assign evt_line_end   = pulses.line_end;
  assign cpu_stall      = stall_busy;
endmodule

// File: rtl/lse_checker.sv
`timescale 1ns/1ps
module lse_checker (
  input logic clk,
  input logic rst_n,
  input logic step,
  input logic eol_ack,
  input logic evt_hdma_init,
  input logic evt_refresh,
  input logic evt_hdma_start,
  input logic evt_line_end,
  input logic cpu_stall,
  input logic dot_tick
);
  logic [3:0] ev;
  assign ev = {evt_hdma_init, evt_refresh, evt_hdma_start, evt_line_end};

  p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ev) <= 1);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 4'b0) |=> ((ev & $past(ev)) == 4'b0));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (ev == 4'b0) && !dot_tick && $stable(cpu_stall));

  p_stall_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hdma_init || evt_hdma_start || evt_line_end) |-> !cpu_stall);

  p_refresh_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_refresh |-> cpu_stall);

  p_end_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_line_end |-> $past(eol_ack) && $past(step));

  p_end_dot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_line_end |-> dot_tick);
endmodule

bind line_event_sched lse_checker u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .eol_ack(eol_ack),
  .evt_hdma_init(evt_hdma_init), .evt_refresh(evt_refresh),
  .evt_hdma_start(evt_hdma_start), .evt_line_end(evt_line_end),
  .cpu_stall(cpu_stall), .dot_tick(dot_tick)
);

// File: tb/line_event_sched_bench.sv
`timescale 1ns/1ps
module line_event_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step;
  logic [8:0] scanline;
  logic [8:0] vblank_start;
  logic       eol_ack;
  logic       evt_hdma_init, evt_refresh, evt_hdma_start, evt_line_end, cpu_stall, dot_tick;

  int nchk = 0;
  int nerr = 0;
  int total_steps = 0;
  bit fresh = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_event_sched u_line_event_sched (
    .clk(clk), .rst_n(rst_n), .step(step), .scanline(scanline),
    .vblank_start(vblank_start), .eol_ack(eol_ack),
    .evt_hdma_init(evt_hdma_init), .evt_refresh(evt_refresh),
    .evt_hdma_start(evt_hdma_start), .evt_line_end(evt_line_end),
    .cpu_stall(cpu_stall), .dot_tick(dot_tick)
  );

  // {current line, vblank start, retries, next line, idle-gap step}
  localparam int NL = 8;
  localparam int TBL [NL][5] = '{
    '{5,   225, 0, 6,   100},
    '{6,   225, 3, 225, 275},
    '{225, 225, 1, 0,   0},
    '{0,   225, 2, 1,   0},
    '{1,   225, 0, 2,   0},
    '{2,   225, 1, 0,   0},
    '{0,   225, 0, 3,   20},
    '{3,   2,   0, 4,   0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_step(input bit st, input bit ack, input int sl);
    step = st; eol_ack = ack; scanline = 9'(sl);
    @(posedge clk);
    @(negedge clk);
    step = 1'b0; eol_ack = 1'b0;
  endtask

  task automatic run_line(input int cur, input int vbl, input int retries,
                          input int nxt, input int gap_at);
    int ph, ref_pos, init_pos, n, sref, hs, h;
    int b_init, b_ref, b_hs, b_eol, b_stall, b_dot, b_idle;
    bit e_stall;
    b_init = 0; b_ref = 0; b_hs = 0; b_eol = 0; b_stall = 0; b_dot = 0; b_idle = 0;
    ph       = (total_steps * 2) & 7;
    ref_pos  = 538 - ph;
    init_pos = (cur == 0 && !fresh) ? 12 + ph : -1;
    n        = 680 + retries;
    sref     = ref_pos / 2;
    hs       = (cur < vbl) ? 552 : -1;
    vblank_start = 9'(vbl);
    for (int s = 1; s <= n; s++) begin
      // early acknowledge at step 400 must be ignored (R8)
      do_step(1'b1, (s == n) || (retries > 0 && s == 400), (s == n) ? nxt : cur);
      total_steps++;
      h = (s == n) ? 0 : 2 * s;
      e_stall = (s >= sref && s <= sref + 19);
      if (evt_hdma_init  != (2 * s == init_pos)) b_init++;
      if (evt_refresh    != (s == sref))         b_ref++;
      if (evt_hdma_start != (s == hs))           b_hs++;
      if (evt_line_end   != (s == n))            b_eol++;
      if (cpu_stall      != e_stall)             b_stall++;
      if (dot_tick       != (h % 4 == 0))        b_dot++;
      if (s == gap_at) begin
        for (int g = 0; g < 5; g++) begin
          do_step(1'b0, 1'b0, cur);
          if (evt_hdma_init || evt_refresh || evt_hdma_start || evt_line_end ||
              dot_tick || (cpu_stall != e_stall)) b_idle++;
        end
      end
    end
    check(b_init == 0,  "R5", "table-init pulse mismatches", b_init, 0);
    check(b_ref == 0,   "R6", "refresh pulse mismatches", b_ref, 0);
    check(b_stall == 0, "R6", "stall window mismatches", b_stall, 0);
    check(b_hs == 0,    "R7", "transfer-start pulse mismatches", b_hs, 0);
    check(b_eol == 0,   "R8", "line-end pulse mismatches", b_eol, 0);
    check(b_dot == 0,   "R3", "dot tick mismatches", b_dot, 0);
    if (gap_at != 0)
      check(b_idle == 0, "R2", "idle-cycle activity", b_idle, 0);
    fresh = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step = 1'b0; eol_ack = 1'b0;
    scanline = '0; vblank_start = 9'd225;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check({evt_hdma_init, evt_refresh, evt_hdma_start, evt_line_end, cpu_stall, dot_tick} == 6'b0,
          "R1", "outputs under reset", 1, 0);
    rst_n = 1'b1;
    do_step(1'b0, 1'b0, 5);
    check({evt_hdma_init, evt_refresh, evt_hdma_start, evt_line_end, cpu_stall, dot_tick} == 6'b0,
          "R1", "outputs after release", 1, 0);
    total_steps = 0; fresh = 1'b1;

    for (int i = 0; i < NL; i++)
      run_line(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][4]);

    // R1: reset in the middle of a refresh stall, then schedule restarts at 538
    for (int s = 0; s < 280; s++) do_step(1'b1, 1'b0, 9);
    check(cpu_stall == 1'b1, "R6", "stall active before mid-line reset", cpu_stall, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(cpu_stall == 1'b0, "R1", "stall cleared by reset", cpu_stall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    total_steps = 0; fresh = 1'b1;
    run_line(0, 225, 0, 7, 0);   // R1: line 0 right after reset still refreshes first
    run_line(7, 225, 1, 0, 0);
    run_line(0, 225, 0, 8, 0);   // R9: line 0 again, init at 12 + phase

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule